// File: doc/BRIEF.md
# Panel Power Sequencer

This block drives the four power-related enables of a flat display panel and keeps them in a safe order. The four enables are the logic supply, the data signals, the backlight bias and the backlight enable. Each enable switches on its own clock edge, with a programmed wait between one step and the next. Three single-cycle command strobes start the work. One brings the whole panel up. One takes the whole panel down. One switches only the backlight pair on or off, and a direction pin selects which.

Power-up and power-down are not mirror images in time. On shutdown the block waits much longer after removing the bias than at any other step. This gives the backlight inverter time to discharge before the data lines go away. While a sequence runs, the block raises `busy` and ignores every new command. A two-bit status tells the system whether the panel is off, has logic and data only, is fully lit, or is in transition. Both wait lengths are parameters counted in system clock cycles.

Top module: `panel_pwr_seq`

## Requirements
- R1: While reset is asserted and after it is released, `rails` is 4'b0000, `busy` is 0 and `pwr_state` is 0.
- R2: A power-on command taken while idle sets `rails[0]` (supply) on the next clock edge. It then sets `rails[1]` (data), `rails[2]` (bias) and `rails[3]` (backlight) in that order, each `T_STEP` cycles after the one before.
- R3: A power-off command taken while idle clears the rails in the order `rails[3]`, `rails[2]`, `rails[1]`, `rails[0]`. The waits between the clears are `T_STEP`, then `T_LONG`, then `T_STEP` cycles.
- R4: A backlight command with `bl_dir`=1 sets `rails[2]` on the next edge and sets `rails[3]` `T_STEP` cycles later. `rails[1:0]` are not touched.
- R5: A backlight command with `bl_dir`=0 clears `rails[3]` on the next edge and clears `rails[2]` `T_STEP` cycles later. `rails[1:0]` are not touched.
- R6: A backlight-on command has no effect, and does not raise `busy`, unless `rails[0]` and `rails[1]` are both 1.
- R7: A command whose strobe is sampled while `busy` is 1 has no effect on the running sequence or on the rails that follow it.
- R8: `busy` rises on the edge that applies the first step. It falls on the edge that applies the final step. With no command, an idle block stays idle and its rails do not change.
- R9: `pwr_state` is 3 while `busy` is 1. When idle it is 0 for rails 4'b0000, 1 for 4'b0011, 2 for 4'b1111, and 3 for any other value.
- R10: When strobes coincide on an idle block, power-off wins over power-on, and power-on wins over a backlight command.
- R11: At most one rail changes on any edge. The rails stay nested at all times: backlight implies bias, bias implies data, and data implies supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_on | input | 1 | One-cycle strobe: full power-on sequence |
| cmd_off | input | 1 | One-cycle strobe: full power-off sequence |
| cmd_bl | input | 1 | One-cycle strobe: backlight-only sequence |
| bl_dir | input | 1 | Direction for `cmd_bl`: 1 switches on, 0 switches off |
| rails | output | 4 | Enables: bit0 supply, bit1 data, bit2 bias, bit3 backlight |
| busy | output | 1 | A sequence is running |
| pwr_state | output | 2 | 0 off, 1 logic+data, 2 full, 3 transition or other |

## Verification
A wrong step index or sequence kind shows on `rails` on the very next step edge. It appears either as a rail switched out of order, which breaks the nesting rule, or as a rail switched at the wrong time. A wrong timer load moves the following rail edge by at least one cycle, and that is visible within one gap. A stuck or early `busy` shows at once on `pwr_state`, or on the cycle after a command arrives, because an injected command then changes the rails. The bench compares every cycle of every sequence from every idle start state. It injects each command at every offset inside each sequence.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    SEQ_UP   = 2'd0,
    SEQ_DN   = 2'd1,
    SEQ_BLUP = 2'd2,
    SEQ_BLDN = 2'd3
  } seq_e;

  localparam int RAIL_N = 4;

  localparam logic [1:0] PS_OFF   = 2'd0;
  localparam logic [1:0] PS_LOGIC = 2'd1;
  localparam logic [1:0] PS_FULL  = 2'd2;
  localparam logic [1:0] PS_MOVE  = 2'd3;
endpackage

// File: rtl/pps_steps.sv
// Step table: for a sequence kind and a step index, gives the rail to
// change, its new value, whether the long wait follows, and whether the
// step is the final one.
module pps_steps
  import pps_pkg::*;
(
  input  seq_e       kind,
  input  logic [1:0] idx,
  output logic [1:0] rail,
  output logic       val,
  output logic       gap_long,
  output logic       last
);
  always_comb begin
    rail     = idx;
    val      = 1'b1;
    gap_long = 1'b0;
    last     = 1'b0;
    unique case (kind)
      SEQ_UP: begin
        rail = idx;
        val  = 1'b1;
        last = (idx == 2'd3);
      end
      SEQ_DN: begin
        rail     = 2'd3 - idx;
        val      = 1'b0;
        gap_long = (idx == 2'd1);
        last     = (idx == 2'd3);
      end
      SEQ_BLUP: begin
        rail = 2'd2 + idx;
        val  = 1'b1;
        last = (idx == 2'd1);
      end
      SEQ_BLDN: begin
        rail = 2'd3 - idx;
        val  = 1'b0;
        last = (idx == 2'd1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pps_timer.sv
// Down counter. A load sets the count to (gap - 1), and zero then marks
// the edge on which the next step is due.
module pps_timer #(
  parameter int T_STEP = 100000,
  parameter int T_LONG = 20000000,
  parameter int CW     = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_long,
  output logic zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_long ? CW'(T_LONG - 1) : CW'(T_STEP - 1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pps_ctrl.sv
// Takes commands while idle, applies one step per due edge, and loads
// the timer for the gap that follows each step that is not final.
module pps_ctrl
  import pps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_on,
  input  logic              cmd_off,
  input  logic              cmd_bl,
  input  logic              bl_dir,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic              tmr_long,
  output logic [RAIL_N-1:0] rails,
  output logic              busy
);
  seq_e              kind_q, kind_new, cur_kind;
  logic [1:0]        idx_q, cur_idx;
  logic              busy_q, accept, fire;
  logic [RAIL_N-1:0] rails_q;
  logic [1:0]        st_rail;
  logic              st_val, st_long, st_last;

  // Command resolution: off over on over backlight.
  always_comb begin
    accept   = 1'b0;
    kind_new = SEQ_UP;
    if (!busy_q) begin
      if (cmd_off) begin
        accept   = 1'b1;
        kind_new = SEQ_DN;
      end else if (cmd_on) begin
        accept   = 1'b1;
        kind_new = SEQ_UP;
      end else if (cmd_bl && bl_dir && rails_q[0] && rails_q[1]) begin
        accept   = 1'b1;
        kind_new = SEQ_BLUP;
      end else if (cmd_bl && !bl_dir) begin
        accept   = 1'b1;
        kind_new = SEQ_BLDN;
      end
    end
  end

  assign cur_kind = busy_q ? kind_q : kind_new;
  assign cur_idx  = busy_q ? idx_q  : 2'd0;

  pps_steps u_steps (
    .kind     (cur_kind),
    .idx      (cur_idx),
    .rail     (st_rail),
    .val      (st_val),
    .gap_long (st_long),
    .last     (st_last)
  );

  assign fire     = accept | (busy_q & tmr_zero);
  assign tmr_load = fire & ~st_last;
  assign tmr_long = st_long;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rails_q <= '0;
      busy_q  <= 1'b0;
      kind_q  <= SEQ_UP;
      idx_q   <= 2'd0;
    end else begin
      if (fire)
        rails_q[st_rail] <= st_val;
      if (accept) begin
        kind_q <= kind_new;
        busy_q <= 1'b1;
        idx_q  <= 2'd1;
      end else if (busy_q && tmr_zero) begin
        if (st_last)
          busy_q <= 1'b0;
        else
          idx_q <= idx_q + 2'd1;
      end
    end
  end

  assign rails = rails_q;
  assign busy  = busy_q;
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int T_STEP = 100000,
  parameter int T_LONG = 20000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_on,
  input  logic       cmd_off,
  input  logic       cmd_bl,
  input  logic       bl_dir,
  output logic [3:0] rails,
  output logic       busy,
  output logic [1:0] pwr_state
);
  localparam int MAXG = (T_LONG > T_STEP) ? T_LONG : T_STEP;
  localparam int CW   = $clog2(MAXG + 1);

  logic tmr_load, tmr_long, tmr_zero;

  pps_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_on   (cmd_on),
    .cmd_off  (cmd_off),
    .cmd_bl   (cmd_bl),
    .bl_dir   (bl_dir),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_long (tmr_long),
    .rails    (rails),
    .busy     (busy)
  );

  pps_timer #(.T_STEP(T_STEP), .T_LONG(T_LONG), .CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tmr_load),
    .load_long (tmr_long),
    .zero      (tmr_zero)
  );

  always_comb begin
    if (busy)                 pwr_state = PS_MOVE;
    else if (rails == 4'b0000) pwr_state = PS_OFF;
    else if (rails == 4'b0011) pwr_state = PS_LOGIC;
    else if (rails == 4'b1111) pwr_state = PS_FULL;
    else                      pwr_state = PS_MOVE;
  end
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int T_STEP = 100000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_on,
  input logic       cmd_off,
  input logic       cmd_bl,
  input logic       bl_dir,
  input logic [3:0] rails,
  input logic       busy
);
  localparam int SW = $clog2(T_STEP + 1);

  logic [3:0]    rails_d;
  logic          busy_d;
  logic [SW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rails_d <= '0;
      busy_d  <= 1'b0;
      since   <= '0;
    end else begin
      rails_d <= rails;
      busy_d  <= busy;
      if (rails != rails_d)
        since <= SW'(1);
      else if (since < SW'(T_STEP))
        since <= since + 1'b1;
    end
  end

  assert_rail_nest_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rails[3] || rails[2]) && (!rails[2] || rails[1]) && (!rails[1] || rails[0]));

  assert_one_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rails ^ rails_d) <= 1);

  assert_step_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rails != rails_d) && busy_d) |-> (since >= SW'(T_STEP)));

  assert_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rails == 4'b0000 || rails == 4'b0011 || rails == 4'b1111));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_on && !cmd_off && !cmd_bl) |=> (!busy && $stable(rails)));

  assert_bl_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_bl && bl_dir && !cmd_on && !cmd_off && !(rails[0] && rails[1]))
      |=> (!busy && $stable(rails)));
endmodule

bind panel_pwr_seq pps_checker #(.T_STEP(T_STEP)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmd_on  (cmd_on),
  .cmd_off (cmd_off),
  .cmd_bl  (cmd_bl),
  .bl_dir  (bl_dir),
  .rails   (rails),
  .busy    (busy)
);

// File: tb/sim_panel_pwr_seq.sv
module sim_panel_pwr_seq;
  localparam int TS = 3;
  localparam int TL = 11;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_on, cmd_off, cmd_bl, bl_dir;
  logic [3:0] rails;
  logic       busy;
  logic [1:0] pwr_state;

  always #5 clk = ~clk;

  panel_pwr_seq #(.T_STEP(TS), .T_LONG(TL)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .cmd_bl(cmd_bl), .bl_dir(bl_dir), .rails(rails), .busy(busy),
    .pwr_state(pwr_state)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 0;
  logic [3:0] model = 4'b0000;

  task automatic check(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // mask bits: 0 power-on, 1 power-off, 2 backlight on, 3 backlight off
  task automatic drive(input logic [3:0] m);
    cmd_on  = m[0];
    cmd_off = m[1];
    cmd_bl  = m[2] | m[3];
    bl_dir  = m[2];
  endtask

  function automatic int exp_state(input logic [3:0] r, input bit b);
    if (b) return 3;
    if (r == 4'b0000) return 0;
    if (r == 4'b0011) return 1;
    if (r == 4'b1111) return 2;
    return 3;
  endfunction

  task automatic run(input logic [3:0] m, input logic [3:0] inj, input int inj_n, input string req);
    int         kind, nst, tl;
    int         ri[4];
    int         tt[4];
    bit         rv, b;
    logic [3:0] e, prev;
    if (m[1]) kind = 1;
    else if (m[0]) kind = 0;
    else if (m[2] && model[0] && model[1]) kind = 2;
    else if (m[3]) kind = 3;
    else kind = -1;
    nst = 0; rv = 1'b0;
    case (kind)
      0: begin nst = 4; rv = 1'b1; ri = '{0, 1, 2, 3}; tt = '{0, TS, 2*TS, 3*TS}; end
      1: begin nst = 4; rv = 1'b0; ri = '{3, 2, 1, 0}; tt = '{0, TS, TS+TL, 2*TS+TL}; end
      2: begin nst = 2; rv = 1'b1; ri = '{2, 3, 0, 0}; tt = '{0, TS, 0, 0}; end
      3: begin nst = 2; rv = 1'b0; ri = '{3, 2, 0, 0}; tt = '{0, TS, 0, 0}; end
      default: begin ri = '{0, 0, 0, 0}; tt = '{0, 0, 0, 0}; end
    endcase
    tl = (nst == 0) ? 0 : tt[nst-1];
    @(negedge clk); drive(m);
    @(negedge clk); drive(4'b0000);
    prev = model;
    e    = model;
    for (int n = 0; n <= tl + 2; n++) begin
      e = model;
      for (int i = 0; i < nst; i++)
        if (tt[i] <= n) e[ri[i]] = rv;
      b = (n < tl);
      check(req, "rails", int'(rails), int'(e));
      check("R8", "busy", int'(busy), int'(b));
      check("R9", "pwr_state", int'(pwr_state), exp_state(e, b));
      check("R11", "one rail per edge",
            ($countones(rails ^ prev) <= 1) ? 1 : 0, 1);
      check("R11", "nesting",
            ((!rails[3] || rails[2]) && (!rails[2] || rails[1]) && (!rails[1] || rails[0])) ? 1 : 0, 1);
      prev = rails;
      if (n == inj_n) drive(inj); else drive(4'b0000);
      @(negedge clk);
    end
    drive(4'b0000);
    model = e;
  endtask

  task automatic go_to(input logic [3:0] tgt);
    if (model == tgt) return;
    if (tgt == 4'b0000) run(4'b0010, 4'b0000, -1, "R3");
    else if (tgt == 4'b1111) run(4'b0001, 4'b0000, -1, "R2");
    else begin
      if (model != 4'b1111) run(4'b0001, 4'b0000, -1, "R2");
      run(4'b1000, 4'b0000, -1, "R5");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(4'b0000);
    repeat (3) @(negedge clk);
    check("R1", "rails in reset", int'(rails), 0);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "state in reset", int'(pwr_state), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rails after reset", int'(rails), 0);

    // R6: backlight-on from off is ignored
    run(4'b0100, 4'b0000, -1, "R6");
    // R2, R5, R4, R3 in turn
    run(4'b0001, 4'b0000, -1, "R2");
    run(4'b1000, 4'b0000, -1, "R5");
    run(4'b0100, 4'b0000, -1, "R4");
    run(4'b0010, 4'b0000, -1, "R3");
    // R10: coinciding strobes
    run(4'b0011, 4'b0000, -1, "R10");
    run(4'b0101, 4'b0000, -1, "R10");
    run(4'b1010, 4'b0000, -1, "R10");
    // backlight-off from off: rails unchanged, busy for one gap
    run(4'b1000, 4'b0000, -1, "R5");

    // R7: every command injected at every offset inside every sequence
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 4; c++) begin
        int lim;
        lim = (k == 0) ? 3*TS : (k == 1) ? 2*TS + TL : TS;
        for (int n = 0; n < lim; n++) begin
          case (k)
            0: begin go_to(4'b0000); run(4'b0001, 4'(1 << c), n, "R7"); end
            1: begin go_to(4'b1111); run(4'b0010, 4'(1 << c), n, "R7"); end
            2: begin go_to(4'b1111); run(4'b1000, 4'(1 << c), n, "R7"); end
            default: begin go_to(4'b0011); run(4'b0100, 4'(1 << c), n, "R7"); end
          endcase
        end
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule